// File: doc/BRIEF.md
# Synchronous FIFO with Registered Write and Read Error Flags

This block is a single-clock first-in first-out buffer. Words presented on `wr_data` with `wr_en` high are stored while room remains, and `rd_en` pulls the oldest stored word onto `rd_data`. The read port is registered: the word appears on `rd_data` after the clock edge at which the read is accepted, and `rd_data` holds its value between reads. Depth (a power of two, 16 by default), word width and the almost-full threshold are parameters.

Occupancy is tracked by a counter next to the two address pointers. A four-state level machine turns the next occupancy into registered status outputs. Its states are LVL_EMPTY (nothing stored), LVL_LOW (occupancy from 1 up to the threshold minus one), LVL_HIGH (threshold up to depth minus one) and LVL_FULL. Its transitions are named FILL_FIRST (LVL_EMPTY to LVL_LOW or LVL_HIGH), DRAIN_LAST (to LVL_EMPTY), CROSS_UP (LVL_LOW to LVL_HIGH), CROSS_DOWN (LVL_HIGH to LVL_LOW), TOP_OFF (LVL_HIGH to LVL_FULL) and RELEASE (LVL_FULL to LVL_HIGH). The machine stays put when occupancy keeps its class. A write refused because the buffer is full raises `wr_err` on the next edge. A read refused because the buffer is empty raises `rd_err` on the next edge. Both flags are re-evaluated on every rising edge.

Top module: `wff_fifo`

## Requirements
- R1: A rising edge with `rst` high clears pointers, occupancy and all flags. After it, `empty`=1 and `full`=0, `almost_full`=0, `wr_err`=0 and `rd_err`=0.
- R2: Words come out in the order they were accepted. The word taken by an accepted read is on `rd_data` after that read's edge and is held until the next accepted read.
- R3: `full` is 1 after the edge at which occupancy reaches DEPTH, and 0 at every other occupancy.
- R4: `almost_full` is 1 after any edge that leaves occupancy at or above AF_LEVEL (default 12), and 0 after any edge that leaves it below AF_LEVEL.
- R5: A write while full with `rd_en` low is discarded. Occupancy stays at DEPTH, and draining yields exactly the DEPTH words stored earlier.
- R6: While full, a read and a write on the same edge both take effect. `full` stays 1, `wr_err` stays 0, and the new word is read out after the words that were already stored.
- R7: `wr_err` is 1 after every edge at which `wr_en`=1, `full`=1 and `rd_en`=0. It is 0 after the first edge with `wr_en`=0.
- R8: A read while empty is ignored: `rd_data` keeps its value, and `rd_err` is 1 after that edge. `rd_err` is 0 after the first edge with `rd_en`=0.
- R9: With the buffer neither empty nor full, a read and a write on the same edge leave occupancy and all level flags unchanged.
- R10: While empty, a read and a write on the same edge store the word and raise `rd_err`. After the edge, `empty`=0.
- R11: `empty` is 1 after the edge of the read that removes the last word, and 0 after any edge that leaves a word stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Word taken by the last accepted read (registered) |
| full | output | 1 | Occupancy equals DEPTH |
| almost_full | output | 1 | Occupancy at or above AF_LEVEL |
| empty | output | 1 | Occupancy is zero |
| wr_err | output | 1 | The previous edge refused a write |
| rd_err | output | 1 | The previous edge refused a read |

## Verification
The hardest situation to reach is a full buffer that takes a read and a write on the same edge. The write must be kept, not refused, and the freed slot must be handed to the new word without breaking the output order. The stimulus first fills the buffer word by word through the threshold crossing to full. It then holds `wr_en` high for several refused edges and drops it. Next it applies combined read-and-write edges at full. A scoreboard queue then confirms, while draining, that the late word comes out last. Both empty-side corners are driven from reset before any fill: a read alone, and a read combined with a write.

// File: rtl/wff_pkg.sv
package wff_pkg;

    // Occupancy class held by the level machine.
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_LOW   = 2'd1,
        LVL_HIGH  = 2'd2,
        LVL_FULL  = 2'd3
    } lvl_t;

    // Transfers granted on one edge.
    typedef struct packed {
        logic wr_go;
        logic rd_go;
    } xfer_t;

endpackage

// File: rtl/wff_gate.sv
module wff_gate
    import wff_pkg::*;
(
    input  logic  wr_en,
    input  logic  rd_en,
    input  logic  full,
    input  logic  empty,
    output xfer_t xfer
);

    // A read is granted whenever something is stored.
    // A write is granted when room exists or when a read on the same edge frees a slot.
    always_comb begin
        xfer.rd_go = rd_en && !empty;
        xfer.wr_go = wr_en && (!full || xfer.rd_go);
    end

endmodule

// File: rtl/wff_ptrs.sv
module wff_ptrs #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_go,
    input  logic                       rd_go,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [$clog2(DEPTH):0]     occ_next
);

    localparam int AW = $clog2(DEPTH);
    localparam int OW = AW + 1;

    logic [OW-1:0] occ;

    always_comb begin
        unique case ({wr_go, rd_go})
            2'b10:   occ_next = occ + OW'(1);
            2'b01:   occ_next = occ - OW'(1);
            default: occ_next = occ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            rd_addr <= '0;
            occ     <= '0;
        end else begin
            if (wr_go) wr_addr <= wr_addr + AW'(1);
            if (rd_go) rd_addr <= rd_addr + AW'(1);
            occ <= occ_next;
        end
    end

endmodule

// File: rtl/wff_store.sv
module wff_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_go,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_go,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_addr] <= wr_data;
    end

    // Registered read port; the old word is taken before a same-edge write.
    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_go) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/wff_level_fsm.sv
module wff_level_fsm
    import wff_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [$clog2(DEPTH):0] occ_next,
    output logic                   full,
    output logic                   almost_full,
    output logic                   empty
);

    localparam int OW = $clog2(DEPTH) + 1;
    localparam logic [OW-1:0] OCC_TOP = OW'(DEPTH);
    localparam logic [OW-1:0] OCC_AF  = OW'(AF_LEVEL);

    lvl_t state, state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= LVL_EMPTY;
        else     state <= state_nx;
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            LVL_EMPTY: begin
                if (occ_next != '0)                    // FILL_FIRST
                    state_nx = (occ_next >= OCC_AF) ? LVL_HIGH : LVL_LOW;
            end
            LVL_LOW: begin
                if (occ_next == '0)          state_nx = LVL_EMPTY; // DRAIN_LAST
                else if (occ_next >= OCC_AF) state_nx = LVL_HIGH;  // CROSS_UP
            end
            LVL_HIGH: begin
                if (occ_next == OCC_TOP)     state_nx = LVL_FULL;  // TOP_OFF
                else if (occ_next == '0)     state_nx = LVL_EMPTY; // DRAIN_LAST
                else if (occ_next < OCC_AF)  state_nx = LVL_LOW;   // CROSS_DOWN
            end
            LVL_FULL: begin
                if (occ_next != OCC_TOP)     state_nx = LVL_HIGH;  // RELEASE
            end
            default: state_nx = LVL_EMPTY;
        endcase
    end

    // Outputs.
    always_comb begin
        full        = 1'b0;
        almost_full = 1'b0;
        empty       = 1'b0;
        unique case (state)
            LVL_EMPTY: empty = 1'b1;
            LVL_LOW:   ;
            LVL_HIGH:  almost_full = 1'b1;
            LVL_FULL: begin
                full        = 1'b1;
                almost_full = 1'b1;
            end
            default:   empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/wff_err_flags.sv
module wff_err_flags
    import wff_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  rd_en,
    input  xfer_t xfer,
    output logic  wr_err,
    output logic  rd_err
);

    // A request that was not granted on this edge is reported on the next.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_err <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            wr_err <= wr_en && !xfer.wr_go;
            rd_err <= rd_en && !xfer.rd_go;
        end
    end

endmodule

// File: rtl/wff_fifo.sv
module wff_fifo
    import wff_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             almost_full,
    output logic             empty,
    output logic             wr_err,
    output logic             rd_err
);

    localparam int AW = $clog2(DEPTH);

    xfer_t         xfer;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [AW:0]   occ_next;

    wff_gate u_gate (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .full  (full),
        .empty (empty),
        .xfer  (xfer)
    );

    wff_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (xfer.wr_go),
        .rd_go    (xfer.rd_go),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .occ_next (occ_next)
    );

    wff_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (xfer.wr_go),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_go   (xfer.rd_go),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    wff_level_fsm #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_level (
        .clk         (clk),
        .rst         (rst),
        .occ_next    (occ_next),
        .full        (full),
        .almost_full (almost_full),
        .empty       (empty)
    );

    wff_err_flags u_err (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .xfer   (xfer),
        .wr_err (wr_err),
        .rd_err (rd_err)
    );

endmodule

// File: rtl/wff_fifo_chk.sv
module wff_fifo_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             full,
    input logic             almost_full,
    input logic             empty,
    input logic             wr_err,
    input logic             rd_err
);

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R3

    AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (rst)
        full |-> almost_full); // R4

    AST_EMPTY_NOT_AF: assert property (@(posedge clk) disable iff (rst)
        empty |-> !almost_full); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full); // R5

    AST_FULL_RW_KEEP: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en) |=> (full && !wr_err)); // R6

    AST_WRERR_SET: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> wr_err); // R7

    AST_WRERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_err); // R7

    AST_RDERR_SET: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en) |=> rd_err); // R8

    AST_RDERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_err); // R8

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data))); // R8

    AST_EMPTY_RW_STORE: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && wr_en) |=> !empty); // R10

endmodule

bind wff_fifo wff_fifo_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .full        (full),
    .almost_full (almost_full),
    .empty       (empty),
    .wr_err      (wr_err),
    .rd_err      (rd_err)
);

// File: tb/wff_fifo_tb_top.sv
`timescale 1ns/1ps
module wff_fifo_tb_top;

    localparam int WIDTH    = 8;
    localparam int DEPTH    = 16;
    localparam int AF_LEVEL = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             full, almost_full, empty, wr_err, rd_err;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [WIDTH-1:0] model_q[$];
    logic [WIDTH-1:0] chk_q[$];
    int               cnt = 0;
    logic [WIDTH-1:0] last_rd = '0;

    always #10 clk = ~clk;   // 50 MHz

    wff_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .full(full), .almost_full(almost_full), .empty(empty),
        .wr_err(wr_err), .rd_err(rd_err)
    );

    task automatic check(input string what, input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", what, tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus, updates the model, checks the flags.
    task automatic step(input logic we, input logic [WIDTH-1:0] d, input logic re, input string tag);
        bit full_m, empty_m, rd_ok, wr_ok;
        @(negedge clk);
        wr_en = we; wr_data = d; rd_en = re;
        full_m  = (cnt == DEPTH);
        empty_m = (cnt == 0);
        rd_ok   = re && !empty_m;
        wr_ok   = we && (!full_m || rd_ok);
        if (rd_ok) begin
            last_rd = model_q.pop_front();
            chk_q.push_back(last_rd);
        end
        if (wr_ok) model_q.push_back(d);
        cnt = cnt + int'(wr_ok) - int'(rd_ok);
        @(posedge clk);
        #2;
        check("R3 full",        tag, int'(full),        int'(cnt == DEPTH));
        check("R4 almost_full", tag, int'(almost_full), int'(cnt >= AF_LEVEL));
        check("R11 empty",      tag, int'(empty),       int'(cnt == 0));
        check("R7 wr_err",      tag, int'(wr_err),      int'(we && !wr_ok));
        check("R8 rd_err",      tag, int'(rd_err),      int'(re && !rd_ok));
        if (!rd_ok) check("R2 rd_data held", tag, int'(rd_data), int'(last_rd));
    endtask

    // Monitor: compares each word taken by an accepted read.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (chk_q.size() > 0) begin
                logic [WIDTH-1:0] e;
                e = chk_q.pop_front();
                check("R2 read order", "scoreboard", int'(rd_data), int'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired (all) actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset with junk requests pending
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1;
        check("R1 empty after reset",  "R1", int'(empty), 1);
        check("R1 full after reset",   "R1", int'(full), 0);
        check("R1 af after reset",     "R1", int'(almost_full), 0);
        check("R1 wr_err after reset", "R1", int'(wr_err), 0);
        check("R1 rd_err after reset", "R1", int'(rd_err), 0);
        check("R1 rd_data after reset", "R1", int'(rd_data), 0);
        rst = 1'b0;

        // R8: reads while empty, then release
        step(1'b0, 8'h00, 1'b1, "R8 empty read");
        step(1'b0, 8'h00, 1'b1, "R8 empty read again");
        step(1'b0, 8'h00, 1'b0, "R8 rd_en low");

        // R10: read and write together while empty
        step(1'b1, 8'hA5, 1'b1, "R10 empty rw");
        check("R10 stored", "R10", int'(empty), 0);
        step(1'b0, 8'h00, 1'b0, "R10 idle");

        // R3/R4: fill to full through the threshold
        for (int i = 0; cnt < DEPTH; i++)
            step(1'b1, WIDTH'(8'h10 + i), 1'b0, "R4 fill");
        check("R3 full reached", "R3", int'(full), 1);

        // R5/R7: refused writes, then drop wr_en
        step(1'b1, 8'hF1, 1'b0, "R5 write while full");
        step(1'b1, 8'hF2, 1'b0, "R5 write while full");
        step(1'b1, 8'hF3, 1'b0, "R7 wr_err held");
        check("R7 wr_err held", "R7", int'(wr_err), 1);
        step(1'b0, 8'h00, 1'b0, "R7 wr_en low");
        check("R7 wr_err cleared", "R7", int'(wr_err), 0);

        // R6: read and write together while full
        step(1'b1, 8'hC1, 1'b1, "R6 full rw");
        step(1'b1, 8'hC2, 1'b1, "R6 full rw");
        check("R6 full kept", "R6", int'(full), 1);
        check("R6 no wr_err", "R6", int'(wr_err), 0);

        // R4/R9: drain below the threshold, then combined transfers in the middle
        for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1, "R4 drain");
        for (int i = 0; i < 4; i++) step(1'b1, WIDTH'(8'h60 + i), 1'b1, "R9 mid rw");
        check("R9 level kept", "R9", int'(almost_full), 0);
        step(1'b0, 8'h00, 1'b0, "R9 idle");

        // R11/R5: drain everything; refused words must never appear
        while (cnt > 0) step(1'b0, 8'h00, 1'b1, "R11 drain");
        check("R11 empty reached", "R11", int'(empty), 1);
        step(1'b0, 8'h00, 1'b1, "R8 read past empty");

        // Mixed pattern
        for (int i = 0; i < 40; i++)
            step(((i % 3) != 2), WIDTH'(8'h80 + i), ((i % 4) == 1), "R2 mixed");
        while (cnt > 0) step(1'b0, 8'h00, 1'b1, "R2 final drain");

        repeat (3) @(posedge clk);
        #5;
        check("R2 scoreboard drained", "R2", chk_q.size(), 0);
        finish_run();
    end

endmodule